// File: doc/BRIEF.md
# Smart-Panel Command and Pixel Bridge

This block sits between a 32-bit register bus and up to two external display panels that each hold their own frame memory. Software uses it to send command words, parameter words and pixel data to the panels over a 16-bit parallel path. Each panel has its own write strobe and read strobe. A shared register-select line (`pnl_a0`) tells the panel whether a word is a command (low) or a parameter or pixel (high). Two selection bits in the control register decide which panels take part in a write, so one access can reach both panels at once.

A sequencer with five states drives the panel side:
- `ST_IDLE`: waits for a register access.
- `ST_EMIT_ONE`: sends a command or parameter.
- `ST_EMIT_LO` and `ST_EMIT_HI`: send the two half-words of a pixel word, in that order.
- `ST_FETCH`: reads a word from a panel into the receive buffer.

The transitions are:
- `ST_IDLE` goes to `ST_EMIT_ONE` on a command or parameter write, to `ST_EMIT_LO` on a pixel write, and to `ST_FETCH` on a fetch write.
- `ST_EMIT_LO` goes to `ST_EMIT_HI`.
- `ST_EMIT_ONE`, `ST_EMIT_HI` and `ST_FETCH` go back to `ST_IDLE`.

While the sequencer is out of `ST_IDLE`, `bus_stall` holds off the next bus write.

A pixel counter counts down once for each pixel or fetch access. An automatic transfer can be armed from the control register. It sets a busy flag, and the access that brings the counter to zero clears busy and pulses `frame_done` toward the display controller.

Top module: `rfb_bridge`

The register map uses byte addresses:

| Address | Register |
|---|---|
| 0x00 | system config |
| 0x04 | system status |
| 0x08 | control |
| 0x0C | pixel count |
| 0x10 | line |
| 0x14 | command |
| 0x18 | parameter |
| 0x1C | pixel data |
| 0x20 | fetch with A0 high |
| 0x24 | fetch with A0 low |
| 0x28 | config 0 |
| 0x2C | config 1 |
| 0x40 to 0x54 | six data-cycle registers |
| 0x58, 0x5C | two sync-width registers |

A write is accepted on a rising edge where `reg_wr` is high and `bus_stall` is low. Reads are combinational on `reg_addr`.

## Requirements
- R1: After reset, the registers read as follows:
  - control reads 0x2.
  - both config registers read 0x00310000.
  - system status reads 0x1.
  - pixel count, line, system config, the data-cycle registers, the sync-width registers and the receive buffer read 0.
- R2: Stored widths are as follows:
  - Control keeps bits 3:0: bit 0 enable, bit 1 bypass, bit 2 selects panel 0, bit 3 selects panel 1.
  - Line keeps 11 bits.
  - Each config register is masked with 0x003F1FFF.
  - Each data-cycle register is masked with 0x0F1F0F1F.
  - Each sync-width register keeps 16 bits.
  - System config is masked with 0x19.
- R3: An accepted command write drives, in the next cycle only, `pnl_wr` equal to the control panel-select bits, `pnl_a0`=0 and `pnl_wdata` equal to the low 16 bits of the written value.
- R4: An accepted parameter write does the same as R3, but with `pnl_a0`=1.
- R5: An accepted pixel-data write produces two panel writes with `pnl_a0`=1 on the two following cycles. The first carries bits 15:0 of the written value and the second carries bits 31:16.
- R6: `bus_stall` is high from the acceptance edge until the last panel cycle of that access has been issued. A write held on the bus during that time is not accepted until `bus_stall` falls.
- R7: Fetches fill the 16-bit receive buffer from a panel:
  - A fetch write pulses `pnl_rd` for one cycle on panel 0 if it is selected, otherwise on panel 1, and loads that panel's read data into the receive buffer.
  - The fetch at 0x20 uses `pnl_a0`=1 and the fetch at 0x24 uses `pnl_a0`=0.
  - Reading either fetch address returns the buffer zero-extended.
  - With no panel selected there is no strobe and the buffer is unchanged.
- R8: Each accepted pixel-data or fetch write decrements the pixel count, wrapping from 0 to all ones. The pixel count register reads back the current value.
- R9: Writing control with bit 4 set starts an automatic transfer only if all of the following hold:
  - bits 3:2 of (config 0 AND config 1) are zero;
  - the written enable bit is 1;
  - the written bypass bit is 0;
  - busy is clear;
  - `panel_mode_en` is high.
  A started transfer sets busy, which reads as system status bit 8. Bit 4 is not stored.
- R10: Completion of an automatic transfer works as follows:
  - While busy, the access that brings the pixel count to zero clears busy and pulses `frame_done` high for exactly one cycle.
  - A start while the count is already zero completes at once: `frame_done` pulses and busy stays clear.
- R11: A system config write with bit 1 set returns control, config, line, data-cycle, sync-width, pixel count and busy to their reset values, and stores the written value masked with 0x19. The receive buffer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write request, held until accepted |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| bus_stall | output | 1 | High while a panel access is in progress; writes are held off |
| panel_mode_en | input | 1 | Display controller's panel-bus mode enable |
| frame_done | output | 1 | One-cycle pulse when an automatic transfer completes |
| pnl_wr | output | 2 | Per-panel write strobes |
| pnl_rd | output | 2 | Per-panel read strobes |
| pnl_a0 | output | 1 | Register-select line: 0 for command or status, 1 for parameter, pixel or data |
| pnl_wdata | output | 16 | Panel write data |
| pnl_rdata0 | input | 16 | Read data from panel 0, sampled during its read strobe |
| pnl_rdata1 | input | 16 | Read data from panel 1, sampled during its read strobe |

## Verification
The properties assume that a requester keeps `reg_wr`, `reg_addr` and `reg_wdata` steady until the write is accepted. They also assume that panel read data is valid in the cycle of the read strobe. The bench drives bus signals only at falling edges and waits for `bus_stall` to be low before it presents a new write. Only the hold-off test deliberately changes the request while stalled, in order to show that nothing is accepted. The panel models return fixed per-panel values, so the captured buffer contents are known.

// File: rtl/rfb_pkg.sv
package rfb_pkg;
    localparam int WORD_W  = 32;
    localparam int HALF_W  = WORD_W / 2;
    localparam int ADDR_W  = 8;
    localparam int N_PANEL = 2;
    localparam int N_DCYC  = 6;
    localparam int N_SYNC  = 2;
    localparam int CTRL_W  = 2 + N_PANEL;

    localparam logic [ADDR_W-1:0] OFS_SYSCFG = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SYSSTA = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PIXCNT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_LINE   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CMD    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PARAM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_DATA   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_RDHI   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RDLO   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CFG0   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_CFG1   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_DCYC   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_SYNC   = 8'h58;

    localparam logic [WORD_W-1:0] CFG_MASK  = 32'h003F_1FFF;
    localparam logic [WORD_W-1:0] CFG_RST   = 32'h0031_0000;
    localparam logic [WORD_W-1:0] DCYC_MASK = 32'h0F1F_0F1F;
    localparam logic [WORD_W-1:0] IDLE_MASK = 32'h0000_0019;
    localparam logic [WORD_W-1:0] LINE_MASK = 32'h0000_07FF;
    localparam logic [WORD_W-1:0] SYNC_MASK = 32'h0000_FFFF;
    localparam logic [CTRL_W-1:0] CTRL_RST  = 4'h2;

    typedef enum logic [2:0] {
        ACC_NONE, ACC_CMD, ACC_PARAM, ACC_DATA, ACC_RDHI, ACC_RDLO
    } acc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EMIT_ONE, ST_EMIT_LO, ST_EMIT_HI, ST_FETCH
    } seq_state_t;
endpackage

// File: rtl/rfb_regfile.sv
module rfb_regfile
    import rfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              soft_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] cfg0_q,
    output logic [WORD_W-1:0] cfg1_q,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] idle_q, line_q;
    logic [WORD_W-1:0] dcyc_q [N_DCYC];
    logic [WORD_W-1:0] sync_q [N_SYNC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
            line_q <= '0;
            ctrl_q <= CTRL_RST;
            cfg0_q <= CFG_RST;
            cfg1_q <= CFG_RST;
        end else if (soft_rst) begin
            idle_q <= wdata & IDLE_MASK;
            line_q <= '0;
            ctrl_q <= CTRL_RST;
            cfg0_q <= CFG_RST;
            cfg1_q <= CFG_RST;
        end else if (wr_go) begin
            case (addr)
                OFS_SYSCFG: idle_q <= wdata & IDLE_MASK;
                OFS_CTRL:   ctrl_q <= wdata[CTRL_W-1:0];
                OFS_LINE:   line_q <= wdata & LINE_MASK;
                OFS_CFG0:   cfg0_q <= wdata & CFG_MASK;
                OFS_CFG1:   cfg1_q <= wdata & CFG_MASK;
                default: ;
            endcase
        end
    end

    for (genvar gi = 0; gi < N_DCYC; gi++) begin : g_dcyc
        localparam logic [ADDR_W-1:0] MY_OFS = OFS_DCYC + ADDR_W'(4 * gi);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dcyc_q[gi] <= '0;
            else if (soft_rst)
                dcyc_q[gi] <= '0;
            else if (wr_go && addr == MY_OFS)
                dcyc_q[gi] <= wdata & DCYC_MASK;
        end
    end

    for (genvar gs = 0; gs < N_SYNC; gs++) begin : g_sync
        localparam logic [ADDR_W-1:0] MY_OFS = OFS_SYNC + ADDR_W'(4 * gs);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sync_q[gs] <= '0;
            else if (soft_rst)
                sync_q[gs] <= '0;
            else if (wr_go && addr == MY_OFS)
                sync_q[gs] <= wdata & SYNC_MASK;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_SYSCFG: rdata = idle_q;
            OFS_CTRL:   rdata = WORD_W'(ctrl_q);
            OFS_LINE:   rdata = line_q;
            OFS_CFG0:   rdata = cfg0_q;
            OFS_CFG1:   rdata = cfg1_q;
            default: ;
        endcase
        for (int i = 0; i < N_DCYC; i++)
            if (addr == OFS_DCYC + ADDR_W'(4 * i)) rdata = dcyc_q[i];
        for (int i = 0; i < N_SYNC; i++)
            if (addr == OFS_SYNC + ADDR_W'(4 * i)) rdata = sync_q[i];
    end
endmodule

// File: rtl/rfb_xfer_ctl.sv
module rfb_xfer_ctl
    import rfb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              cnt_load,
    input  logic              cnt_dec,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] cfg_and,
    input  logic              panel_mode_en,
    output logic [CNT_W-1:0]  pix_q,
    output logic              busy_q,
    output logic              done_q
);
    logic             start_ok;
    logic [CNT_W-1:0] pix_dec;

    assign pix_dec  = pix_q - CNT_W'(1);
    assign start_ok = ctrl_wr && wdata[4] && (cfg_and[3:2] == 2'b00) &&
                      wdata[0] && !wdata[1] && !busy_q && panel_mode_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (soft_rst) begin
            pix_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cnt_load) begin
                pix_q <= wdata[CNT_W-1:0];
            end else if (cnt_dec) begin
                pix_q <= pix_dec;
                if (busy_q && pix_dec == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
            if (start_ok) begin
                if (pix_q == '0) done_q <= 1'b1;
                else             busy_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfb_panel_seq.sv
module rfb_panel_seq
    import rfb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  acc_t               acc,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [N_PANEL-1:0] sel,
    input  logic [HALF_W-1:0]  rdata0,
    input  logic [HALF_W-1:0]  rdata1,
    output logic               stall,
    output logic [N_PANEL-1:0] pnl_wr,
    output logic [N_PANEL-1:0] pnl_rd,
    output logic               pnl_a0,
    output logic [HALF_W-1:0]  pnl_wdata,
    output logic [HALF_W-1:0]  rx_q
);
    seq_state_t        state_q, state_d;
    logic [WORD_W-1:0] hold_q;
    logic              a0_q;
    logic [N_PANEL-1:0] sel_q, rd_pick;

    assign rd_pick = sel_q[0] ? 2'b01 : (sel_q[1] ? 2'b10 : 2'b00);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (acc)
                    ACC_CMD, ACC_PARAM: state_d = ST_EMIT_ONE;
                    ACC_DATA:           state_d = ST_EMIT_LO;
                    ACC_RDHI, ACC_RDLO: state_d = ST_FETCH;
                    ACC_NONE:           state_d = ST_IDLE;
                    default:            state_d = ST_IDLE;
                endcase
            end
            ST_EMIT_LO:  state_d = ST_EMIT_HI;
            ST_EMIT_ONE: state_d = ST_IDLE;
            ST_EMIT_HI:  state_d = ST_IDLE;
            ST_FETCH:    state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
            a0_q    <= 1'b0;
            sel_q   <= '0;
            rx_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && acc != ACC_NONE) begin
                hold_q <= wdata;
                sel_q  <= sel;
                a0_q   <= (acc == ACC_PARAM) || (acc == ACC_DATA) || (acc == ACC_RDHI);
            end
            if (state_q == ST_FETCH) begin
                if (sel_q[0])      rx_q <= rdata0;
                else if (sel_q[1]) rx_q <= rdata1;
            end
        end
    end

    always_comb begin
        stall     = 1'b1;
        pnl_wr    = '0;
        pnl_rd    = '0;
        pnl_a0    = 1'b0;
        pnl_wdata = '0;
        unique case (state_q)
            ST_IDLE: stall = 1'b0;
            ST_EMIT_ONE: begin
                pnl_wr    = sel_q;
                pnl_a0    = a0_q;
                pnl_wdata = hold_q[HALF_W-1:0];
            end
            ST_EMIT_LO: begin
                pnl_wr    = sel_q;
                pnl_a0    = 1'b1;
                pnl_wdata = hold_q[HALF_W-1:0];
            end
            ST_EMIT_HI: begin
                pnl_wr    = sel_q;
                pnl_a0    = 1'b1;
                pnl_wdata = hold_q[WORD_W-1:HALF_W];
            end
            ST_FETCH: begin
                pnl_rd = rd_pick;
                pnl_a0 = a0_q;
            end
            default: stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfb_bridge.sv
module rfb_bridge
    import rfb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_stall,
    input  logic              panel_mode_en,
    output logic              frame_done,
    output logic [1:0]        pnl_wr,
    output logic [1:0]        pnl_rd,
    output logic              pnl_a0,
    output logic [15:0]       pnl_wdata,
    input  logic [15:0]       pnl_rdata0,
    input  logic [15:0]       pnl_rdata1
);
    logic              wr_go, soft_rst;
    acc_t              acc;
    logic [CTRL_W-1:0] ctrl_q;
    logic [WORD_W-1:0] cfg0_q, cfg1_q, cfg_rdata;
    logic [CNT_W-1:0]  pix_q;
    logic              busy_q;
    logic [HALF_W-1:0] rx_q;

    assign wr_go    = reg_wr && !bus_stall;
    assign soft_rst = wr_go && reg_addr == OFS_SYSCFG && reg_wdata[1];

    always_comb begin
        acc = ACC_NONE;
        if (wr_go) begin
            case (reg_addr)
                OFS_CMD:   acc = ACC_CMD;
                OFS_PARAM: acc = ACC_PARAM;
                OFS_DATA:  acc = ACC_DATA;
                OFS_RDHI:  acc = ACC_RDHI;
                OFS_RDLO:  acc = ACC_RDLO;
                default:   acc = ACC_NONE;
            endcase
        end
    end

    rfb_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .soft_rst(soft_rst),
        .addr(reg_addr), .wdata(reg_wdata), .ctrl_q(ctrl_q),
        .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .rdata(cfg_rdata)
    );

    rfb_xfer_ctl #(.CNT_W(CNT_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cnt_load(wr_go && reg_addr == OFS_PIXCNT),
        .cnt_dec(acc == ACC_DATA || acc == ACC_RDHI || acc == ACC_RDLO),
        .ctrl_wr(wr_go && reg_addr == OFS_CTRL),
        .wdata(reg_wdata), .cfg_and(cfg0_q & cfg1_q),
        .panel_mode_en(panel_mode_en),
        .pix_q(pix_q), .busy_q(busy_q), .done_q(frame_done)
    );

    rfb_panel_seq u_seq (
        .clk(clk), .rst_n(rst_n), .acc(acc), .wdata(reg_wdata),
        .sel(ctrl_q[3:2]), .rdata0(pnl_rdata0), .rdata1(pnl_rdata1),
        .stall(bus_stall), .pnl_wr(pnl_wr), .pnl_rd(pnl_rd),
        .pnl_a0(pnl_a0), .pnl_wdata(pnl_wdata), .rx_q(rx_q)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_SYSSTA:         reg_rdata = {23'd0, busy_q, 7'd0, 1'b1};
            OFS_PIXCNT:         reg_rdata = WORD_W'(pix_q);
            OFS_RDHI, OFS_RDLO: reg_rdata = {{HALF_W{1'b0}}, rx_q};
            default:            reg_rdata = cfg_rdata;
        endcase
    end
endmodule

// File: rtl/rfb_bridge_chk.sv
module rfb_bridge_chk
    import rfb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        bus_stall,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [1:0]  pnl_wr,
    input logic [1:0]  pnl_rd,
    input logic        pnl_a0,
    input logic [15:0] pnl_wdata,
    input logic        frame_done,
    input logic [1:0]  sel,
    input logic        busy
);
    logic acc_ok;
    assign acc_ok = reg_wr && !bus_stall;

    assert_cmd_a0_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && reg_addr == OFS_CMD) |=>
        (!pnl_a0 && pnl_wdata == $past(reg_wdata[15:0]) && pnl_wr == $past(sel)));

    assert_param_a0_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && reg_addr == OFS_PARAM) |=>
        (pnl_a0 && pnl_wdata == $past(reg_wdata[15:0]) && pnl_wr == $past(sel)));

    assert_data_low_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && reg_addr == OFS_DATA) |=>
        (pnl_a0 && pnl_wdata == $past(reg_wdata[15:0]) && pnl_wr == $past(sel)));

    assert_data_high_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && reg_addr == OFS_DATA) |=> ##1
        (pnl_a0 && pnl_wdata == $past(reg_wdata[31:16], 2)));

    assert_stall_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (reg_addr == OFS_CMD || reg_addr == OFS_PARAM || reg_addr == OFS_DATA ||
                    reg_addr == OFS_RDHI || reg_addr == OFS_RDLO)) |=> bus_stall);

    assert_single_reader_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pnl_rd) && !((|pnl_rd) && (|pnl_wr)));

    assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);
endmodule

bind rfb_bridge rfb_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .bus_stall(bus_stall),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pnl_wr(pnl_wr), .pnl_rd(pnl_rd),
    .pnl_a0(pnl_a0), .pnl_wdata(pnl_wdata), .frame_done(frame_done),
    .sel(ctrl_q[3:2]), .busy(busy_q)
);

// File: tb/rfb_bridge_tb_top.sv
module rfb_bridge_tb_top;
    localparam logic [7:0] A_SYSCFG = 8'h00, A_SYSSTA = 8'h04, A_CTRL = 8'h08,
        A_PIX = 8'h0C, A_LINE = 8'h10, A_CMD = 8'h14, A_PARAM = 8'h18,
        A_DATA = 8'h1C, A_RDHI = 8'h20, A_RDLO = 8'h24, A_CFG0 = 8'h28,
        A_CFG1 = 8'h2C, A_DCYC3 = 8'h4C, A_SYNC1 = 8'h5C;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, panel_mode_en = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic bus_stall, frame_done, pnl_a0;
    logic [1:0] pnl_wr, pnl_rd;
    logic [15:0] pnl_wdata, pnl_rdata0, pnl_rdata1;

    int n_checks = 0, n_fail = 0, fd_count = 0, ev_n = 0;
    bit finished = 0;
    logic [1:0]  ev_mask [256];
    logic        ev_a0   [256];
    logic [15:0] ev_data [256];
    logic        ev_rd   [256];

    assign pnl_rdata0 = 16'h1234;
    assign pnl_rdata1 = 16'hBEEF;

    always #10 clk = ~clk;

    rfb_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_stall(bus_stall),
        .panel_mode_en(panel_mode_en), .frame_done(frame_done), .pnl_wr(pnl_wr),
        .pnl_rd(pnl_rd), .pnl_a0(pnl_a0), .pnl_wdata(pnl_wdata),
        .pnl_rdata0(pnl_rdata0), .pnl_rdata1(pnl_rdata1)
    );

    always @(negedge clk) begin
        if (rst_n && frame_done) fd_count++;
        if (rst_n && ((|pnl_wr) || (|pnl_rd)) && ev_n < 256) begin
            ev_mask[ev_n] = (|pnl_wr) ? pnl_wr : pnl_rd;
            ev_a0[ev_n]   = pnl_a0;
            ev_data[ev_n] = pnl_wdata;
            ev_rd[ev_n]   = |pnl_rd;
            ev_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        while (bus_stall) @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        while (bus_stall) @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic int exp_count(input int op, input logic [1:0] s);
        if (s == 2'b00) return 0;
        return (op == 2) ? 2 : 1;
    endfunction

    function automatic logic [15:0] exp_half(input int op, input int k, input logic [31:0] d);
        return (op == 2 && k == 1) ? d[31:16] : d[15:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(A_CTRL, v);   check("R1 ctrl", v, 32'h2);
        rd(A_CFG0, v);   check("R1 cfg0", v, 32'h0031_0000);
        rd(A_CFG1, v);   check("R1 cfg1", v, 32'h0031_0000);
        rd(A_SYSSTA, v); check("R1 status", v, 32'h1);
        rd(A_PIX, v);    check("R1 pixcnt", v, 32'h0);
        rd(A_RDHI, v);   check("R1 rxbuf", v, 32'h0);
        rd(A_SYNC1, v);  check("R1 sync", v, 32'h0);

        // R2 masks
        wr(A_CTRL, 32'hFFFF_FFEF);  rd(A_CTRL, v);   check("R2 ctrl", v, 32'hF);
        wr(A_LINE, 32'hFFFF_FFFF);  rd(A_LINE, v);   check("R2 line", v, 32'h7FF);
        wr(A_CFG0, 32'hFFFF_FFFF);  rd(A_CFG0, v);   check("R2 cfg0", v, 32'h003F_1FFF);
        wr(A_DCYC3, 32'hFFFF_FFFF); rd(A_DCYC3, v);  check("R2 dcyc", v, 32'h0F1F_0F1F);
        wr(A_SYNC1, 32'hFFFF_FFFF); rd(A_SYNC1, v);  check("R2 sync", v, 32'hFFFF);
        wr(A_SYSCFG, 32'hFFFF_FFFD); rd(A_SYSCFG, v); check("R2 syscfg", v, 32'h19);
        wr(A_CFG0, 32'h0031_0000);

        // R3 R4 R5 random command/parameter/pixel traffic
        for (int it = 0; it < 40; it++) begin
            logic [1:0] s;
            int op;
            logic [31:0] d;
            s = 2'($urandom % 4);
            op = int'($urandom % 3);
            d = $urandom;
            wr(A_CTRL, {28'd0, s, 2'b00});
            settle();
            ev_n = 0;
            wr(op == 0 ? A_CMD : (op == 1 ? A_PARAM : A_DATA), d);
            settle();
            check(op == 0 ? "R3 count" : (op == 1 ? "R4 count" : "R5 count"),
                  ev_n, exp_count(op, s));
            for (int k = 0; k < exp_count(op, s) && k < ev_n; k++) begin
                check(op == 0 ? "R3 event" : (op == 1 ? "R4 event" : "R5 event"),
                      {ev_rd[k], 12'd0, ev_mask[k], ev_a0[k], ev_data[k]},
                      {1'b0, 12'd0, s, (op != 0), exp_half(op, k, d)});
            end
        end

        // R6 hold-off while stalled
        wr(A_CTRL, 32'h4);
        settle();
        ev_n = 0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'hCAFE_0123;
        @(negedge clk);
        check("R6 stall lo", bus_stall, 1'b1);
        reg_addr = A_PARAM; reg_wdata = 32'h0000_0777;
        @(negedge clk);
        check("R6 stall hi", bus_stall, 1'b1);
        @(negedge clk);
        check("R6 stall end", bus_stall, 1'b0);
        @(negedge clk);
        reg_wr = 1'b0;
        settle();
        check("R6 event count", ev_n, 3);
        check("R6 order", {ev_data[0], ev_data[1]}, 32'h0123_CAFE);
        check("R6 held write", {15'd0, ev_a0[2], ev_data[2]}, 32'h0001_0777);

        // R7 fetches
        wr(A_CTRL, 32'hC);
        settle(); ev_n = 0;
        wr(A_RDHI, 32'h0); settle();
        rd(A_RDHI, v); check("R7 rx panel0", v, 32'h1234);
        check("R7 strobe hi", {ev_n[7:0], 6'd0, ev_mask[0], ev_a0[0], ev_rd[0]}, {8'd1, 6'd0, 2'b01, 1'b1, 1'b1});
        wr(A_CTRL, 32'h8);
        settle(); ev_n = 0;
        wr(A_RDLO, 32'h0); settle();
        rd(A_RDLO, v); check("R7 rx panel1", v, 32'hBEEF);
        check("R7 strobe lo", {ev_n[7:0], 6'd0, ev_mask[0], ev_a0[0], ev_rd[0]}, {8'd1, 6'd0, 2'b10, 1'b0, 1'b1});
        wr(A_CTRL, 32'h0);
        settle(); ev_n = 0;
        wr(A_RDHI, 32'h0); settle();
        rd(A_RDHI, v); check("R7 none selected keeps rx", v, 32'hBEEF);
        check("R7 none selected no strobe", ev_n, 0);

        // R8 pixel counter
        wr(A_PIX, 32'd5);
        wr(A_DATA, 32'h1); wr(A_DATA, 32'h2); wr(A_RDLO, 32'h0);
        settle(); rd(A_PIX, v); check("R8 decrement", v, 32'd2);
        wr(A_PIX, 32'd0); wr(A_DATA, 32'h3);
        settle(); rd(A_PIX, v); check("R8 wrap", v, 32'hFFFF_FFFF);

        // R9 refused starts
        wr(A_PIX, 32'd3);
        panel_mode_en = 1'b0;
        wr(A_CTRL, 32'h15); settle(); rd(A_SYSSTA, v); check("R9 no panel mode", v, 32'h1);
        panel_mode_en = 1'b1;
        wr(A_CTRL, 32'h17); settle(); rd(A_SYSSTA, v); check("R9 bypass set", v, 32'h1);
        wr(A_CTRL, 32'h14); settle(); rd(A_SYSSTA, v); check("R9 not enabled", v, 32'h1);
        wr(A_CFG0, 32'h4); wr(A_CFG1, 32'h4);
        wr(A_CTRL, 32'h15); settle(); rd(A_SYSSTA, v); check("R9 config blocks", v, 32'h1);
        wr(A_CFG1, 32'h0031_0000);
        rd(A_CTRL, v); check("R9 bit4 not stored", v, 32'h5);

        // R9 R10 started transfer
        fd_count = 0;
        wr(A_PIX, 32'd2);
        wr(A_CTRL, 32'h15); settle(); rd(A_SYSSTA, v); check("R9 busy set", v, 32'h101);
        wr(A_DATA, 32'h10); settle(); rd(A_SYSSTA, v); check("R10 still busy", v, 32'h101);
        check("R10 no early done", fd_count, 0);
        wr(A_DATA, 32'h20); settle(); rd(A_SYSSTA, v); check("R10 busy cleared", v, 32'h1);
        check("R10 one done pulse", fd_count, 1);
        wr(A_PIX, 32'd0);
        wr(A_CTRL, 32'h15); settle(); rd(A_SYSSTA, v); check("R10 zero-count start busy", v, 32'h1);
        check("R10 zero-count done", fd_count, 2);

        // R11 soft reset
        wr(A_PIX, 32'd3); wr(A_CTRL, 32'h15); wr(A_LINE, 32'd5);
        settle(); rd(A_SYSSTA, v); check("R11 busy before", v, 32'h101);
        wr(A_SYSCFG, 32'h3); settle();
        rd(A_CTRL, v);   check("R11 ctrl", v, 32'h2);
        rd(A_PIX, v);    check("R11 pixcnt", v, 32'h0);
        rd(A_SYSSTA, v); check("R11 busy", v, 32'h1);
        rd(A_LINE, v);   check("R11 line", v, 32'h0);
        rd(A_CFG0, v);   check("R11 cfg0", v, 32'h0031_0000);
        rd(A_SYSCFG, v); check("R11 syscfg", v, 32'h1);
        rd(A_RDHI, v);   check("R11 rx kept", v, 32'hBEEF);
        check("R11 no done", fd_count, 2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule